// File: doc/BRIEF.md
# Fractional-Rate Time-of-Day Counter

This block keeps a running time of day in the usual precision-time layout: a 48-bit seconds count and a 30-bit nanoseconds count that wraps at one billion. It runs from a local oscillator. On every clock edge it adds a programmable increment to the time. The increment has an integer-nanosecond part and a 24-bit fractional part, so the rate can be trimmed far below one nanosecond per tick. The fraction sits in an accumulator, and each carry out of it adds one more nanosecond to that tick.

Control inputs in the counter's own clock domain load a new time and write a new increment. The time is driven out in parallel, through a fixed number of register stages, for a timestamping unit. A host in a separate clock domain reads the time with a toggle request and acknowledge handshake. The handshake returns a seconds/nanoseconds pair that was captured in a single cycle.

Top module: `tod_rtc`

## Requirements
- R1: While `rst` is high, the nanoseconds count, the seconds count and the fractional accumulator are cleared. `tod_sec` and `tod_ns` read 0 from the first edge with `rst` high.
- R2: `inc_val[31:24]` holds whole nanoseconds and `inc_val[23:0]` holds a fraction in units of 2^-24 ns. On each edge the fraction is added to the 24-bit accumulator. The time advances by the whole part plus the carry out of that addition.
- R3: The nanoseconds count stays below 1,000,000,000. A tick that reaches or passes that value subtracts it and adds one to the seconds count.
- R4: A pulse on `inc_wr` stores `inc_val`, and the new value is used from the following edge onward. Reset does not alter the stored increment.
- R5: With `load_en` high at an edge, the time becomes exactly `load_sec`/`load_ns` at that edge, and no increment is added. The fraction accumulator keeps accumulating. `load_ns` must be below 1,000,000,000.
- R6: `tod_sec`/`tod_ns` show the internal time of `PIPE_STAGES` (default 2) edges earlier. A load is therefore visible after `PIPE_STAGES`+1 edges.
- R7: A one-cycle `rd_req` pulse in the host domain is answered by a one-cycle `rd_done` pulse. `rd_sec`/`rd_ns` then hold one internal time value sampled between the request and the answer. They do not change except together with `rd_done`.
- R8: A `rd_req` that arrives while a read is still outstanding is ignored, and produces no additional `rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset of the time (counter domain) |
| load_en | input | 1 | Load strobe for the time |
| load_sec | input | 48 | Seconds value to load |
| load_ns | input | 30 | Nanoseconds value to load |
| inc_wr | input | 1 | Write strobe for the increment |
| inc_val | input | 32 | Increment: [31:24] ns, [23:0] fraction |
| tod_sec | output | 48 | Pipelined seconds output |
| tod_ns | output | 30 | Pipelined nanoseconds output |
| host_clk | input | 1 | Host clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| rd_req | input | 1 | Read request pulse (host domain) |
| rd_done | output | 1 | Read answer pulse (host domain) |
| rd_sec | output | 48 | Seconds of the captured time |
| rd_ns | output | 30 | Nanoseconds of the captured time |

## Verification
A load or increment write changes the internal time at the next edge. The parallel output reflects that change two more edges later. The bench therefore keeps a reference model with the same two-stage delay and compares the outputs on every falling edge, half a cycle after the counter edge. A read completes after an unknown number of edges in both domains. For that reason the captured value is checked against a window: the model time at the request bounds it from below, and the model time when `rd_done` is seen bounds it from above. With the increment set to zero the window collapses and the value must match exactly. For R8, the bench counts `rd_done` pulses over a fixed span of host cycles after two requests in quick succession.

// File: rtl/tod_rtc_pkg.sv
package tod_rtc_pkg;
    localparam int SEC_W   = 48;
    localparam int NS_W    = 30;
    localparam int INT_W   = 8;
    localparam int FRAC_W  = 24;
    localparam int INC_W   = INT_W + FRAC_W;
    localparam int STEP_W  = INT_W + 1;
    localparam int NSX_W   = NS_W + 1;
    localparam logic [NSX_W-1:0] NS_WRAP = NSX_W'(1_000_000_000);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    // advance a time value by a whole number of nanoseconds
    function automatic tod_t tod_advance(tod_t t, logic [STEP_W-1:0] step);
        tod_t r;
        logic [NSX_W-1:0] s;
        s = {1'b0, t.ns} + NSX_W'(step);
        if (s >= NS_WRAP) begin
            r.ns  = NS_W'(s - NS_WRAP);
            r.sec = t.sec + 1'b1;
        end else begin
            r.ns  = NS_W'(s);
            r.sec = t.sec;
        end
        return r;
    endfunction
endpackage

// File: rtl/tod_accum.sv
module tod_accum
    import tod_rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  tod_t             load_tod,
    input  logic             inc_wr,
    input  logic [INC_W-1:0] inc_val,
    output tod_t             now
);
    logic [INC_W-1:0]  inc_q;
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W:0]   frac_sum;
    logic [STEP_W-1:0] step;
    tod_t              tod_q;

    always_comb begin
        frac_sum = {1'b0, frac_q} + {1'b0, inc_q[FRAC_W-1:0]};
        step     = {1'b0, inc_q[INC_W-1:FRAC_W]} + STEP_W'(frac_sum[FRAC_W]);
    end

    // rate setting lives outside the reset on purpose
    always_ff @(posedge clk) begin
        if (inc_wr)
            inc_q <= inc_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            tod_q  <= '0;
        end else begin
            frac_q <= frac_sum[FRAC_W-1:0];
            tod_q  <= load_en ? load_tod : tod_advance(tod_q, step);
        end
    end

    assign now = tod_q;

    // checker state: set once an increment has been written
    logic inc_seen;
    always_ff @(posedge clk) begin
        if (inc_wr)
            inc_seen <= 1'b1;
        else if (inc_seen !== 1'b1)
            inc_seen <= 1'b0;
    end

    assert_ns_range_R3: assert property (@(posedge clk) disable iff (rst)
        tod_q.ns < NS_W'(1_000_000_000));

    assert_sec_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && ({1'b0, tod_q.ns} + NSX_W'(step) >= NS_WRAP))
        |=> tod_q.sec == $past(tod_q.sec) + 1'b1);

    assert_load_exact_R5: assert property (@(posedge clk) disable iff (rst)
        load_en |=> tod_q == $past(load_tod));

    // deliberately not gated by rst: reset must leave the rate alone
    assert_inc_kept_R4: assert property (@(posedge clk) disable iff (inc_seen !== 1'b1)
        !inc_wr |=> $stable(inc_q));
endmodule

// File: rtl/tod_out_pipe.sv
module tod_out_pipe
    import tod_rtc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  tod_t d,
    output tod_t q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_regs
            tod_t stage_q [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)
                        stage_q[i] <= '0;
                    else if (i == 0)
                        stage_q[i] <= d;
                    else
                        stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                end
            end
            assign q = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tod_read_xfer.sv
module tod_read_xfer
    import tod_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  tod_t live,
    input  logic host_clk,
    input  logic host_rst,
    input  logic rd_req,
    output logic rd_done,
    output tod_t rd_tod
);
    // host side
    logic req_t, ack_s1, ack_s2, ack_s3, busy;
    // counter side
    logic rq_s1, rq_s2, rq_s3, ack_t;
    tod_t snap_q;

    assign busy = req_t ^ ack_s2;

    always_ff @(posedge host_clk) begin
        if (host_rst) begin
            req_t   <= 1'b0;
            ack_s1  <= 1'b0;
            ack_s2  <= 1'b0;
            ack_s3  <= 1'b0;
            rd_done <= 1'b0;
            rd_tod  <= '0;
        end else begin
            ack_s1  <= ack_t;
            ack_s2  <= ack_s1;
            ack_s3  <= ack_s2;
            if (rd_req && !busy)
                req_t <= ~req_t;
            rd_done <= ack_s2 ^ ack_s3;
            if (ack_s2 ^ ack_s3)
                rd_tod <= snap_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_s1  <= 1'b0;
            rq_s2  <= 1'b0;
            rq_s3  <= 1'b0;
            ack_t  <= 1'b0;
            snap_q <= '0;
        end else begin
            rq_s1 <= req_t;
            rq_s2 <= rq_s1;
            rq_s3 <= rq_s2;
            if (rq_s2 ^ rq_s3) begin
                snap_q <= live;
                ack_t  <= ~ack_t;
            end
        end
    end

    assert_done_single_R7: assert property (@(posedge host_clk) disable iff (host_rst)
        rd_done |=> !rd_done);

    assert_result_hold_R7: assert property (@(posedge host_clk) disable iff (host_rst)
        !rd_done |-> $stable(rd_tod));

    assert_busy_ignore_R8: assert property (@(posedge host_clk) disable iff (host_rst)
        busy |=> req_t == $past(req_t));
endmodule

// File: rtl/tod_rtc.sv
module tod_rtc
    import tod_rtc_pkg::*;
#(
    parameter int PIPE_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    input  logic [NS_W-1:0]  load_ns,
    input  logic             inc_wr,
    input  logic [INC_W-1:0] inc_val,
    output logic [SEC_W-1:0] tod_sec,
    output logic [NS_W-1:0]  tod_ns,
    input  logic             host_clk,
    input  logic             host_rst,
    input  logic             rd_req,
    output logic             rd_done,
    output logic [SEC_W-1:0] rd_sec,
    output logic [NS_W-1:0]  rd_ns
);
    tod_t load_tod, now, out_tod, rd_tod;

    assign load_tod = '{sec: load_sec, ns: load_ns};

    tod_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_tod (load_tod),
        .inc_wr   (inc_wr),
        .inc_val  (inc_val),
        .now      (now)
    );

    tod_out_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (now),
        .q   (out_tod)
    );

    tod_read_xfer u_xfer (
        .clk      (clk),
        .rst      (rst),
        .live     (now),
        .host_clk (host_clk),
        .host_rst (host_rst),
        .rd_req   (rd_req),
        .rd_done  (rd_done),
        .rd_tod   (rd_tod)
    );

    assign tod_sec = out_tod.sec;
    assign tod_ns  = out_tod.ns;
    assign rd_sec  = rd_tod.sec;
    assign rd_ns   = rd_tod.ns;

    assert_out_range_R3: assert property (@(posedge clk) disable iff (rst)
        tod_ns < NS_W'(1_000_000_000));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (now == '0));
endmodule

// File: tb/tod_rtc_test.sv
module tod_rtc_test;
    localparam int P = 2;
    localparam longint unsigned BILLION = 64'd1_000_000_000;

    logic        clk = 1'b0, host_clk = 1'b0;
    logic        rst = 1'b1, host_rst = 1'b1;
    logic        load_en = 1'b0, inc_wr = 1'b0, rd_req = 1'b0;
    logic [47:0] load_sec = '0;
    logic [29:0] load_ns = '0;
    logic [31:0] inc_val = '0;
    logic [47:0] tod_sec, rd_sec;
    logic [29:0] tod_ns, rd_ns;
    logic        rd_done;

    always #2 clk = ~clk;
    always #3 host_clk = ~host_clk;

    tod_rtc #(.PIPE_STAGES(P)) uut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_sec(load_sec),
        .load_ns(load_ns), .inc_wr(inc_wr), .inc_val(inc_val),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .host_clk(host_clk),
        .host_rst(host_rst), .rd_req(rd_req), .rd_done(rd_done),
        .rd_sec(rd_sec), .rd_ns(rd_ns)
    );

    int n_checks = 0, n_fail = 0;
    string tag = "R1";

    // reference model
    logic [47:0] m_sec = '0, p_sec [P];
    logic [29:0] m_ns = '0, p_ns [P];
    logic [23:0] m_frac = '0;
    logic [31:0] m_inc = '0;

    initial for (int i = 0; i < P; i++) begin p_sec[i] = '0; p_ns[i] = '0; end

    function automatic logic [95:0] total(logic [47:0] s, logic [29:0] n);
        return 96'(s) * 96'(BILLION) + 96'(n);
    endfunction

    always @(posedge clk) begin
        logic [24:0] fs;
        longint unsigned nn;
        for (int i = P-1; i > 0; i--) begin
            p_sec[i] = rst ? '0 : p_sec[i-1];
            p_ns[i]  = rst ? '0 : p_ns[i-1];
        end
        p_sec[0] = rst ? '0 : m_sec;
        p_ns[0]  = rst ? '0 : m_ns;
        fs = 25'(m_frac) + 25'(m_inc[23:0]);
        if (rst) begin
            m_sec = '0; m_ns = '0; m_frac = '0;
        end else begin
            m_frac = fs[23:0];
            if (load_en) begin
                m_sec = load_sec; m_ns = load_ns;
            end else begin
                nn = longint'(m_ns) + longint'(m_inc[31:24]) + longint'(fs[24]);
                if (nn >= BILLION) begin nn = nn - BILLION; m_sec = m_sec + 1; end
                m_ns = 30'(nn);
            end
        end
        if (inc_wr) m_inc = inc_val;
    end

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check({tod_sec, tod_ns} == {p_sec[P-1], p_ns[P-1]}, tag,
              total(tod_sec, tod_ns), total(p_sec[P-1], p_ns[P-1]));
        load_en = 1'b0;
        inc_wr  = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic set_inc(input logic [31:0] v);
        inc_val = v; inc_wr = 1'b1; cyc();
    endtask

    task automatic set_time(input logic [47:0] s, input logic [29:0] n);
        load_sec = s; load_ns = n; load_en = 1'b1; cyc();
    endtask

    // one read; returns captured total and window bounds
    task automatic host_read(output logic [95:0] got, output logic [95:0] lo, output logic [95:0] hi);
        int w;
        @(negedge host_clk);
        rd_req = 1'b1;
        lo = total(m_sec, m_ns);
        @(negedge host_clk);
        rd_req = 1'b0;
        w = 0;
        while (!rd_done && w < 60) begin @(negedge host_clk); w++; end
        hi = total(m_sec, m_ns);
        got = total(rd_sec, rd_ns);
        check(rd_done === 1'b1, "R7", 96'(rd_done), 96'd1);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [95:0] got, lo, hi;
        int dones;
        void'($urandom(32'd1588));
        // R1: reset state, increment programmed during reset
        inc_val = 32'h08_000000; inc_wr = 1'b1;
        run(4);
        check(tod_sec == '0 && tod_ns == '0, "R1", total(tod_sec, tod_ns), 96'd0);
        rst = 1'b0; host_rst = 1'b0;
        tag = "R2"; run(20);
        check(tod_ns == 30'(8 * (20 - P)), "R2", 96'(tod_ns), 96'(8 * (20 - P)));

        // R2: half-nanosecond rate
        set_inc(32'h00_800000);
        set_time(48'd0, 30'd0);
        run(30);
        set_inc(32'h03_555555);
        run(40);

        // R5 / R6: load and pipeline lag
        set_inc(32'h08_000000);
        tag = "R6";
        load_sec = 48'hABC; load_ns = 30'd100; load_en = 1'b1;
        for (int k = 1; k <= P + 1; k++) begin
            cyc();
            if (k <= P)
                check(tod_sec != 48'hABC, "R6", 96'(tod_sec), 96'd0);
            else
                check(tod_sec == 48'hABC && tod_ns == 30'd100, "R5",
                      total(tod_sec, tod_ns), total(48'hABC, 30'd100));
        end

        // R3: nanosecond wrap into seconds
        tag = "R3";
        set_time(48'd5, 30'd999_999_980);
        run(12);
        check(tod_sec == 48'd6, "R3", 96'(tod_sec), 96'd6);
        set_inc(32'hFF_FFFFFF);
        set_time(48'hFFFF_FFFF_FFFE, 30'd999_999_900);
        run(10);

        // R4: reset keeps the increment
        tag = "R4";
        set_inc(32'h03_400000);
        run(10);
        rst = 1'b1; run(2); rst = 1'b0;
        run(12);
        check(tod_ns == 30'd32, "R4", 96'(tod_ns), 96'd32);

        // mixed random traffic
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(99);
            if (r < 3) begin
                load_sec = {16'($urandom), 32'($urandom)};
                load_ns  = (r == 0) ? 30'(999_999_000 + $urandom_range(999))
                                    : 30'($urandom_range(999_999_999));
                load_en  = 1'b1;
            end
            if (r >= 3 && r < 6) begin
                inc_val = $urandom; inc_wr = 1'b1;
            end
            if (r == 99) begin rst = 1'b1; end else begin rst = 1'b0; end
            cyc();
        end
        rst = 1'b0;
        run(3);

        // R7: frozen time gives an exact read
        set_inc(32'h00_000000);
        set_time(48'h12_3456_789A, 30'd987_654_321);
        run(3);
        host_read(got, lo, hi);
        check(got == total(48'h12_3456_789A, 30'd987_654_321), "R7", got,
              total(48'h12_3456_789A, 30'd987_654_321));

        // R7: running time read within its window
        set_inc(32'h07_A00000);
        set_time(48'd77, 30'd999_999_500);
        for (int j = 0; j < 6; j++) begin
            host_read(got, lo, hi);
            check(got >= lo && got <= hi, "R7", got, lo);
            repeat (5) @(negedge host_clk);
        end

        // R8: second request while busy is dropped
        @(negedge host_clk); rd_req = 1'b1;
        @(negedge host_clk); rd_req = 1'b0;
        @(negedge host_clk); rd_req = 1'b1;
        dones = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge host_clk);
            rd_req = 1'b0;
            if (rd_done) dones++;
        end
        check(dones == 1, "R8", 96'(dones), 96'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule